// File: doc/BRIEF.md
# PCI Configuration Status Register

This block holds the 16-bit status word of a bridge function's PCI configuration header. The word sits at byte offset 06h–07h, which is word address 03h. Six of its bits are sticky error flags. Each flag latches an abort or parity event that the bridge logic reports on a one-cycle strobe. Each flag has its own qualifying condition. For example, the signaled-system-error flag needs the system-error enable, and the initiator data-parity flag needs three conditions to be true together. The remaining bits are constant capability fields.

Software reads the word on `rdata_o`, which always shows the registered state. Software clears a flag by writing a one to its position, and only the lanes named by the byte enables take part. A parameter selects a reduced variant in which both parity flags are tied to zero.

Top module: `pci_status_reg`

## Requirements
- R1: After reset, `rdata_o` reads 0280h in both variants.
- R2: Bit 15 sets on `perr_ev_i` whatever the value of `per_en_i`.
- R3: Bit 14 sets when `serr_ev_i` is high and `serr_en_i` is 1. With `serr_en_i` at 0, a system-error event leaves bit 14 unchanged.
- R4: Bit 13 sets on `mabort_ev_i`, bit 12 on `tabort_rcv_ev_i` and bit 11 on `tabort_sig_ev_i`.
- R5: Bit 8 sets only when `initiator_i` is 1 and `per_en_i` is 1 and a parity error is flagged. The flag comes from `perr_drv_i` when `read_cyc_i` is 1, and from `perr_obs_i` when `read_cyc_i` is 0.
- R6: A write to word address 03h with a 1 in a flag position clears that flag, and a 0 in that position leaves the flag unchanged. Flags stay set until cleared.
- R7: Byte enable bit 0 gates clears of bits 7:0, and byte enable bit 1 gates clears of bits 15:8.
- R8: When a set condition and a clear hit the same flag in the same cycle, the flag ends set.
- R9: Bits 10:9 always read 01, bit 7 always reads 1, and bits 6:0 always read 0, whatever is written.
- R10: With `REDUCED`=1, bits 15 and 8 always read 0, whatever the events and writes.
- R11: An event or write shows on `rdata_o` only after the next rising clock edge. Before that edge, the read value is the earlier registered state.
- R12: A write to any word address other than 03h changes no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_waddr_i | input | 7 | Configuration word address |
| cfg_be_i | input | 2 | Byte enables for the write |
| cfg_wdata_i | input | 16 | Write data (a one clears the flag at that position) |
| perr_ev_i | input | 1 | Parity error event |
| serr_ev_i | input | 1 | System error raised by the function |
| mabort_ev_i | input | 1 | Master abort generated |
| tabort_rcv_ev_i | input | 1 | Target abort received |
| tabort_sig_ev_i | input | 1 | Target abort signaled |
| perr_drv_i | input | 1 | Function drove a parity error on a read it initiated |
| perr_obs_i | input | 1 | Function observed a parity error on a write it initiated |
| per_en_i | input | 1 | Parity error response enable |
| serr_en_i | input | 1 | System error enable |
| initiator_i | input | 1 | Function is the initiator of the current cycle |
| read_cyc_i | input | 1 | Current cycle is a read |
| rdata_o | output | 16 | Registered status word |

## Verification
The assertions take every strobe and qualifier to be a clean, X-free level that is sampled once per rising edge. The stall property for foreign addresses also assumes that no event arrives during that write. The bench changes its inputs only on falling edges and holds each value for exactly one cycle. It returns all event lines to zero between steps, so the no-effect write cases always run with every strobe low. It drives every combination of the eleven event and qualifier inputs, both on its own and together with a full clear. It also sweeps walking-one write data across all byte-enable codes, at both the matching address and a foreign one.

// File: rtl/pci_stat_pkg.sv
package pci_stat_pkg;
  localparam int STAT_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int N_FLAGS = 6;

  localparam int B_PAR_DET   = 15;
  localparam int B_SYS_SIG   = 14;
  localparam int B_MST_ABT   = 13;
  localparam int B_TGT_RCV   = 12;
  localparam int B_TGT_SIG   = 11;
  localparam int B_DPAR_INIT = 8;

  localparam int         B_DEVSEL_LO = 9;
  localparam int         B_FB2B      = 7;
  localparam logic [1:0] DEVSEL_MED  = 2'b01;

  localparam logic [STAT_W-1:0] CONST_BITS =
    (STAT_W'(DEVSEL_MED) << B_DEVSEL_LO) | (STAT_W'(1) << B_FB2B);

  function automatic int flag_pos(input int idx);
    case (idx)
      0:       return B_PAR_DET;
      1:       return B_SYS_SIG;
      2:       return B_MST_ABT;
      3:       return B_TGT_RCV;
      4:       return B_TGT_SIG;
      default: return B_DPAR_INIT;
    endcase
  endfunction

  function automatic logic [STAT_W-1:0] flag_mask();
    logic [STAT_W-1:0] m;
    m = '0;
    for (int i = 0; i < N_FLAGS; i++) m[flag_pos(i)] = 1'b1;
    return m;
  endfunction

  function automatic bit is_parity_pos(input int pos);
    return (pos == B_PAR_DET) || (pos == B_DPAR_INIT);
  endfunction
endpackage

// File: rtl/pci_stat_flag.sv
module pci_stat_flag #(
  parameter bit HARDWIRE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  if (HARDWIRE) begin : g_tie
    logic unused_tie;
    assign unused_tie = ^{clk_i, rst_ni, set_i, clr_i};
    assign q_o = 1'b0;
  end else begin : g_live
    logic q_q;
    // set has priority over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_q <= 1'b0;
      else if (set_i)  q_q <= 1'b1;
      else if (clr_i)  q_q <= 1'b0;
    end
    assign q_o = q_q;

    a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i |=> q_o);
    a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_i) |=> !q_o);
    a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i && !clr_i) |=> $stable(q_o));
  end
endmodule

// File: rtl/pci_stat_qual.sv
module pci_stat_qual
  import pci_stat_pkg::*;
(
  input  logic              perr_ev_i,
  input  logic              serr_ev_i,
  input  logic              mabort_ev_i,
  input  logic              tabort_rcv_ev_i,
  input  logic              tabort_sig_ev_i,
  input  logic              perr_drv_i,
  input  logic              perr_obs_i,
  input  logic              per_en_i,
  input  logic              serr_en_i,
  input  logic              initiator_i,
  input  logic              read_cyc_i,
  output logic [STAT_W-1:0] set_o
);
  logic dpar_flagged;
  // reads: parity error was driven; writes: it was observed
  assign dpar_flagged = read_cyc_i ? perr_drv_i : perr_obs_i;

  always_comb begin
    set_o              = '0;
    set_o[B_PAR_DET]   = perr_ev_i;
    set_o[B_SYS_SIG]   = serr_ev_i & serr_en_i;
    set_o[B_MST_ABT]   = mabort_ev_i;
    set_o[B_TGT_RCV]   = tabort_rcv_ev_i;
    set_o[B_TGT_SIG]   = tabort_sig_ev_i;
    set_o[B_DPAR_INIT] = initiator_i & per_en_i & dpar_flagged;
  end
endmodule

// File: rtl/pci_stat_wdec.sv
module pci_stat_wdec #(
  parameter int          ADDR_W    = 7,
  parameter int unsigned REG_WADDR = 3,
  parameter int          DATA_W    = 16,
  localparam int         BE_W      = DATA_W / 8
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] clr_o
);
  logic hit;
  assign hit = wr_i && (waddr_i == ADDR_W'(REG_WADDR));

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign clr_o[b*8 +: 8] = wdata_i[b*8 +: 8] & {8{hit & be_i[b]}};
  end
endmodule

// File: rtl/pci_status_reg.sv
module pci_status_reg
  import pci_stat_pkg::*;
#(
  parameter int          ADDR_W    = 7,
  parameter int unsigned REG_WADDR = 3,
  parameter bit          REDUCED   = 1'b0,
  localparam int         BE_W      = STAT_W / BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [ADDR_W-1:0] cfg_waddr_i,
  input  logic [BE_W-1:0]   cfg_be_i,
  input  logic [STAT_W-1:0] cfg_wdata_i,
  input  logic              perr_ev_i,
  input  logic              serr_ev_i,
  input  logic              mabort_ev_i,
  input  logic              tabort_rcv_ev_i,
  input  logic              tabort_sig_ev_i,
  input  logic              perr_drv_i,
  input  logic              perr_obs_i,
  input  logic              per_en_i,
  input  logic              serr_en_i,
  input  logic              initiator_i,
  input  logic              read_cyc_i,
  output logic [STAT_W-1:0] rdata_o
);
  localparam logic [STAT_W-1:0] FLAG_MASK = flag_mask();

  logic [STAT_W-1:0] set_vec, clr_vec, flag_vec;
  logic              q_arr [N_FLAGS];

  pci_stat_qual u_qual (
    .perr_ev_i       (perr_ev_i),
    .serr_ev_i       (serr_ev_i),
    .mabort_ev_i     (mabort_ev_i),
    .tabort_rcv_ev_i (tabort_rcv_ev_i),
    .tabort_sig_ev_i (tabort_sig_ev_i),
    .perr_drv_i      (perr_drv_i),
    .perr_obs_i      (perr_obs_i),
    .per_en_i        (per_en_i),
    .serr_en_i       (serr_en_i),
    .initiator_i     (initiator_i),
    .read_cyc_i      (read_cyc_i),
    .set_o           (set_vec)
  );

  pci_stat_wdec #(
    .ADDR_W    (ADDR_W),
    .REG_WADDR (REG_WADDR),
    .DATA_W    (STAT_W)
  ) u_wdec (
    .wr_i    (cfg_wr_i),
    .waddr_i (cfg_waddr_i),
    .be_i    (cfg_be_i),
    .wdata_i (cfg_wdata_i),
    .clr_o   (clr_vec)
  );

  for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
    localparam int P = flag_pos(i);
    pci_stat_flag #(
      .HARDWIRE (REDUCED && is_parity_pos(P))
    ) u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_vec[P]),
      .clr_i  (clr_vec[P]),
      .q_o    (q_arr[i])
    );
  end

  always_comb begin
    flag_vec = '0;
    for (int i = 0; i < N_FLAGS; i++) flag_vec[flag_pos(i)] = q_arr[i];
  end

  assign rdata_o = flag_vec | CONST_BITS;

  logic unused_bits;
  assign unused_bits = ^{set_vec & ~FLAG_MASK, clr_vec & ~FLAG_MASK};

  a_r9_const_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~FLAG_MASK) == CONST_BITS);
  a_r3_serr_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!serr_en_i && !rdata_o[B_SYS_SIG]) |=> !rdata_o[B_SYS_SIG]);
  a_r5_dpar_needs_per: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!per_en_i && !rdata_o[B_DPAR_INIT]) |=> !rdata_o[B_DPAR_INIT]);
  a_r12_foreign_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr_i && cfg_waddr_i != ADDR_W'(REG_WADDR) && !perr_ev_i && !serr_ev_i
     && !mabort_ev_i && !tabort_rcv_ev_i && !tabort_sig_ev_i && !perr_drv_i
     && !perr_obs_i) |=> $stable(rdata_o));

  if (REDUCED) begin : g_chk_reduced
    a_r10_parity_tied: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rdata_o[B_PAR_DET] && !rdata_o[B_DPAR_INIT]);
  end else begin : g_chk_full
    a_r2_parity_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      perr_ev_i |=> rdata_o[B_PAR_DET]);
  end
endmodule

// File: tb/tb_pci_status_reg.sv
`timescale 1ns/1ps
module tb_pci_status_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr;
  logic [6:0]  waddr;
  logic [1:0]  be;
  logic [15:0] wdata;
  logic [10:0] ev;
  logic [15:0] rd_full, rd_red;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  // ev bits: 0 parity,1 sys,2 mabort,3 trcv,4 tsig,5 drv,6 obs,7 per,8 serr,9 init,10 read
  pci_status_reg #(.REDUCED(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(wr), .cfg_waddr_i(waddr),
    .cfg_be_i(be), .cfg_wdata_i(wdata), .perr_ev_i(ev[0]), .serr_ev_i(ev[1]),
    .mabort_ev_i(ev[2]), .tabort_rcv_ev_i(ev[3]), .tabort_sig_ev_i(ev[4]),
    .perr_drv_i(ev[5]), .perr_obs_i(ev[6]), .per_en_i(ev[7]), .serr_en_i(ev[8]),
    .initiator_i(ev[9]), .read_cyc_i(ev[10]), .rdata_o(rd_full));

  pci_status_reg #(.REDUCED(1'b1)) dut_red (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(wr), .cfg_waddr_i(waddr),
    .cfg_be_i(be), .cfg_wdata_i(wdata), .perr_ev_i(ev[0]), .serr_ev_i(ev[1]),
    .mabort_ev_i(ev[2]), .tabort_rcv_ev_i(ev[3]), .tabort_sig_ev_i(ev[4]),
    .perr_drv_i(ev[5]), .perr_obs_i(ev[6]), .per_en_i(ev[7]), .serr_en_i(ev[8]),
    .initiator_i(ev[9]), .read_cyc_i(ev[10]), .rdata_o(rd_red));

  function automatic logic [15:0] exp_set(input logic [10:0] c, input bit red);
    logic [15:0] f;
    f = '0;
    f[15] = c[0];
    f[14] = c[1] & c[8];
    f[13] = c[2];
    f[12] = c[3];
    f[11] = c[4];
    f[8]  = c[9] & c[7] & (c[10] ? c[5] : c[6]);
    if (red) begin f[15] = 1'b0; f[8] = 1'b0; end
    return f;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [10:0] c, input logic w, input logic [6:0] a,
                       input logic [1:0] b, input logic [15:0] d);
    @(negedge clk);
    ev = c; wr = w; waddr = a; be = b; wdata = d;
  endtask

  initial begin
    #1_500_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    ev = '0; wr = 1'b0; waddr = '0; be = '0; wdata = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 full", rd_full, 16'h0280);
    chk("R1 reduced", rd_red, 16'h0280);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R10 R11: every event/qualifier combination
    for (int c = 0; c < 2048; c++) begin
      drive('0, 1'b1, 7'h03, 2'b11, 16'hFFFF);
      drive(11'(c), 1'b0, 7'h00, 2'b00, 16'h0000);
      #1;
      chk("R11 before edge", rd_full, 16'h0280);
      drive('0, 1'b0, 7'h00, 2'b00, 16'h0000);
      #1;
      chk("R2 R3 R4 R5 full", rd_full, 16'h0280 | exp_set(11'(c), 1'b0));
      chk("R10 reduced", rd_red, 16'h0280 | exp_set(11'(c), 1'b1));
      drive('0, 1'b0, 7'h00, 2'b00, 16'h0000);
      #1;
      chk("R6 sticky", rd_full, 16'h0280 | exp_set(11'(c), 1'b0));
    end

    // R8: set and full clear in the same cycle
    for (int c = 0; c < 2048; c++) begin
      drive(11'h7FF, 1'b0, 7'h00, 2'b00, 16'h0000);
      drive(11'(c), 1'b1, 7'h03, 2'b11, 16'hFFFF);
      drive('0, 1'b0, 7'h00, 2'b00, 16'h0000);
      #1;
      chk("R8 full", rd_full, 16'h0280 | exp_set(11'(c), 1'b0));
      chk("R8 reduced", rd_red, 16'h0280 | exp_set(11'(c), 1'b1));
    end

    // R6 R7 R9 R12: write patterns x byte enables x address
    for (int k = 0; k < 18; k++) begin
      for (int b = 0; b < 4; b++) begin
        for (int h = 0; h < 2; h++) begin
          logic [15:0] d, m, cl;
          d = (k < 16) ? (16'h1 << k) : ((k == 16) ? 16'h0000 : 16'hFFFF);
          m = {{8{b[1]}}, {8{b[0]}}};
          cl = (h == 1) ? (d & m) : 16'h0000;
          drive(11'h7FF, 1'b0, 7'h00, 2'b00, 16'h0000);
          drive('0, 1'b1, (h == 1) ? 7'h03 : 7'h05, 2'(b), d);
          drive('0, 1'b0, 7'h00, 2'b00, 16'h0000);
          #1;
          chk((h == 1) ? "R6 R7 R9 full" : "R12 full", rd_full, 16'h0280 | (16'hF900 & ~cl));
          chk((h == 1) ? "R7 R9 R10 reduced" : "R12 reduced", rd_red, 16'h0280 | (16'h7800 & ~cl));
        end
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule